// File: doc/BRIEF.md
# Multi-Burst AXI4 Read Master

This block turns one user read request into as many fixed-length AXI4 INCR read bursts as the request needs. The user gives a start address, a total length counted in data beats and a one-cycle enable. The block issues each burst on the AR channel, waits for the whole burst on the R channel, and then moves the address one stride further. Each burst is 256 beats of 256 bits, so the stride is 0x2000 bytes. If the next burst would start above a programmable end address, the address returns to the request's start address.

Read beats go to the user on a valid/ready/last port. While the user still has beats to take, the user's ready drives RREADY directly, so a stall halts the memory side and no beat is dropped. User last is raised only on the final requested beat of the whole request, never on an intermediate RLAST. If the length is not a whole number of bursts, the beats past the length in the last burst are still accepted from memory but are not shown to the user.

The block stays in reset while the system reset is low or while memory calibration is not complete. Release from reset is synchronized to the clock.

Top module: `mburst_rd_master`

## Requirements
- R1: While `rst_n` is low or `calib_done` is low, `busy`, `ar_valid` and `usr_valid` are 0 and `req_en` has no effect. A request is accepted again from the third clock edge after both are high.
- R2: Every AR burst has `ar_len` = 0xFF (256 beats), `ar_size` = 5 (32 bytes per beat), `ar_burst` = 2'b01 (INCR) and `ar_id` = 0.
- R3: The first AR address of a request equals `req_addr`. Each later AR address is the previous one plus 0x2000.
- R4: If previous address + 0x2000 is greater than `end_addr` (compared without overflow), the next AR address is the request's start address.
- R5: Once `ar_valid` is high, it stays high with `ar_addr` unchanged until `ar_ready` is seen.
- R6: Only one burst is outstanding. After an AR handshake, `ar_valid` stays low until the RLAST beat of that burst is accepted.
- R7: While requested beats remain, `usr_valid` equals `r_valid`, `usr_data` equals `r_data`, and `r_ready` equals `usr_ready`.
- R8: `usr_last` is high only on the beat numbered `req_len`-1 (counting from 0) of the request. RLAST beats that come earlier raise no `usr_last`.
- R9: Beats of the last burst past the requested length are accepted with `r_ready` = 1 while `usr_valid` stays 0.
- R10: `busy` goes high at the clock edge that accepts a request. It falls at the edge after the handshake that both completes the final user beat and accepts RLAST. If the final user beat comes before RLAST, that handshake is the RLAST one.
- R11: `req_en` is ignored while `busy` is high. A request with `req_len` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| calib_done | input | 1 | Memory calibration complete; block held in reset while low |
| end_addr | input | AW | Highest address a burst may start at |
| req_en | input | 1 | One-cycle read request strobe |
| req_addr | input | AW | Start byte address of the request |
| req_len | input | LW | Total request length in beats |
| busy | output | 1 | High while a request is in progress |
| usr_data | output | DW | Read data to the user |
| usr_valid | output | 1 | User data valid |
| usr_last | output | 1 | Final beat of the request |
| usr_ready | input | 1 | User accepts data |
| ar_id | output | IDW | AR transaction ID (always 0) |
| ar_addr | output | AW | AR burst address |
| ar_len | output | 8 | AR burst length code |
| ar_size | output | 3 | AR beat size code |
| ar_burst | output | 2 | AR burst type |
| ar_valid | output | 1 | AR valid |
| ar_ready | input | 1 | AR ready from slave |
| r_data | input | DW | R data from slave |
| r_last | input | 1 | R last beat of burst |
| r_valid | input | 1 | R valid from slave |
| r_ready | output | 1 | R ready to slave |

## Verification
`busy` and the first `ar_valid`/`ar_addr` appear one edge after the edge that samples `req_en`. A later AR appears one edge after the RLAST handshake. The user outputs and `r_ready` are combinational from the R channel and `usr_ready`, so they are checked in the same cycle. `busy` falls one edge after the completing handshake. The bench drives inputs at the falling edge and samples half a nanosecond later. Any handshake it sees there is the one the next rising edge commits, so the model advances in step with the design. A scoreboard compares every user beat, last flag and AR address in order against values built from the requirements.

// File: rtl/mbrd_pkg.sv
`timescale 1ns/1ps
package mbrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } rd_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/mbrd_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the combined reset.
module mbrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mbrd_addr_step.sv
`timescale 1ns/1ps
// Holds the current burst address and the request base; steps with wrap.
module mbrd_addr_step #(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] STRIDE = 'h2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW:0] STRIDE_X = {1'b0, STRIDE};

  logic [AW-1:0] cur_q, cur_d, base_q, base_d;
  logic [AW:0]   sum;
  logic          wrap;
  logic          upd;

  always_comb begin
    sum    = {1'b0, cur_q} + STRIDE_X;
    wrap   = sum > {1'b0, end_addr};
    cur_d  = cur_q;
    base_d = base_q;
    if (load) begin
      cur_d  = load_addr;
      base_d = load_addr;
    end else if (step) begin
      cur_d = wrap ? base_q : sum[AW-1:0];
    end
  end

  assign upd = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
    end else if (upd) begin
      cur_q  <= cur_d;
      base_q <= base_d;
    end
  end

  assign addr_o = cur_q;

  // R3 / R4: a step lands on previous + stride or back on the base
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ((addr_o == $past(cur_q) + STRIDE) || (addr_o == $past(base_q))));
endmodule

// File: rtl/mbrd_beat_track.sv
`timescale 1ns/1ps
// Counts requested beats left, gates user handshake and RREADY.
module mbrd_beat_track #(
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          active,
  input  logic          r_valid,
  input  logic          r_last,
  input  logic          usr_ready,
  output logic          usr_valid,
  output logic          usr_last,
  output logic          r_ready,
  output logic          burst_end,
  output logic          all_done
);
  logic [LW-1:0] rem_q, rem_d;
  logic          have_rem;
  logic          take;
  logic          upd;

  assign have_rem  = rem_q != '0;
  assign usr_valid = active & r_valid & have_rem;
  assign usr_last  = usr_valid & (rem_q == LW'(1));
  assign r_ready   = active & (have_rem ? usr_ready : 1'b1);
  assign take      = usr_valid & usr_ready;
  assign burst_end = active & r_valid & r_ready & r_last;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = load_len;
    else if (take) rem_d = rem_q - LW'(1);
  end

  assign all_done = rem_d == '0;
  assign upd      = load | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem_q <= '0;
    else if (upd) rem_q <= rem_d;
  end

  // R8: after the final user beat no further beat is offered
  assert_last_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && usr_ready && usr_last) |=> !usr_valid);
endmodule

// File: rtl/mburst_rd_master.sv
`timescale 1ns/1ps
module mburst_rd_master
  import mbrd_pkg::*;
#(
  parameter int             AW          = 32,
  parameter int             DW          = 256,
  parameter int             LW          = 32,
  parameter int             IDW         = 4,
  parameter int             BURST_BEATS = 256,
  parameter logic [AW-1:0]  STRIDE      = 'h2000,
  parameter int             SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           calib_done,
  input  logic [AW-1:0]  end_addr,
  input  logic           req_en,
  input  logic [AW-1:0]  req_addr,
  input  logic [LW-1:0]  req_len,
  output logic           busy,
  output logic [DW-1:0]  usr_data,
  output logic           usr_valid,
  output logic           usr_last,
  input  logic           usr_ready,
  output logic [IDW-1:0] ar_id,
  output logic [AW-1:0]  ar_addr,
  output logic [7:0]     ar_len,
  output logic [2:0]     ar_size,
  output logic [1:0]     ar_burst,
  output logic           ar_valid,
  input  logic           ar_ready,
  input  logic [DW-1:0]  r_data,
  input  logic           r_last,
  input  logic           r_valid,
  output logic           r_ready
);
  localparam logic [7:0] LEN_CODE  = 8'(BURST_BEATS - 1);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DW / 8));

  logic      arst_comb_n;
  logic      rst_i_n;
  rd_state_e st_q, st_d;
  logic      start;
  logic      step;
  logic      active;
  logic      burst_end;
  logic      all_done;
  logic      st_upd;

  assign arst_comb_n = rst_n & calib_done;

  mbrd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_comb_n),
    .rst_n_o (rst_i_n)
  );

  assign start  = (st_q == ST_IDLE) && req_en && (req_len != '0);
  assign active = st_q == ST_DATA;
  assign step   = burst_end && !all_done;

  mbrd_addr_step #(.AW(AW), .STRIDE(STRIDE)) i_addr_step (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (start),
    .load_addr (req_addr),
    .step      (step),
    .end_addr  (end_addr),
    .addr_o    (ar_addr)
  );

  mbrd_beat_track #(.LW(LW)) i_beat_track (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (start),
    .load_len  (req_len),
    .active    (active),
    .r_valid   (r_valid),
    .r_last    (r_last),
    .usr_ready (usr_ready),
    .usr_valid (usr_valid),
    .usr_last  (usr_last),
    .r_ready   (r_ready),
    .burst_end (burst_end),
    .all_done  (all_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)     st_d = ST_ADDR;
      ST_ADDR: if (ar_ready)  st_d = ST_DATA;
      ST_DATA: if (burst_end) st_d = all_done ? ST_IDLE : ST_ADDR;
      default:                st_d = ST_IDLE;
    endcase
  end

  assign st_upd = st_d != st_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    st_q <= ST_IDLE;
    else if (st_upd) st_q <= st_d;
  end

  assign busy     = st_q != ST_IDLE;
  assign ar_valid = st_q == ST_ADDR;
  assign ar_id    = '0;
  assign ar_len   = LEN_CODE;
  assign ar_size  = SIZE_CODE;
  assign ar_burst = BURST_INCR;
  assign usr_data = r_data;

  // R5: address request held stable until accepted
  assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

  // R6: no back-to-back address requests; data must come first
  assert_one_burst_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ar_valid && ar_ready) |=> !ar_valid);

  // R9: surplus beats are drained, never stalled
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (active && r_valid && !usr_valid) |-> r_ready);

  // R10: busy only ends on an accepted burst end
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(busy) |-> $past(r_valid && r_ready && r_last));
endmodule

// File: tb/test_mburst_rd_master.sv
`timescale 1ns/1ps
module test_mburst_rd_master;
  localparam int          AW    = 32;
  localparam int          DW    = 256;
  localparam int          LW    = 32;
  localparam int          BEATS = 256;
  localparam logic [31:0] STR   = 32'h2000;

  logic          clk;
  logic          rst_n, calib_done;
  logic [AW-1:0] end_addr, req_addr;
  logic          req_en;
  logic [LW-1:0] req_len;
  logic          busy;
  logic [DW-1:0] usr_data;
  logic          usr_valid, usr_last, usr_ready;
  logic [3:0]    ar_id;
  logic [AW-1:0] ar_addr;
  logic [7:0]    ar_len;
  logic [2:0]    ar_size;
  logic [1:0]    ar_burst;
  logic          ar_valid, ar_ready;
  logic [DW-1:0] r_data;
  logic          r_last, r_valid, r_ready;

  mburst_rd_master i_mburst_rd_master (
    .clk(clk), .rst_n(rst_n), .calib_done(calib_done), .end_addr(end_addr),
    .req_en(req_en), .req_addr(req_addr), .req_len(req_len), .busy(busy),
    .usr_data(usr_data), .usr_valid(usr_valid), .usr_last(usr_last), .usr_ready(usr_ready),
    .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
    .ar_burst(ar_burst), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_data(r_data), .r_last(r_last), .r_valid(r_valid), .r_ready(r_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  logic [AW-1:0] exp_ar[$];
  logic [DW:0]   exp_beat[$];
  logic [AW-1:0] s_pend[$];
  logic          s_act = 1'b0;
  logic [AW-1:0] s_addr = '0;
  int            s_beat = 0;
  bit            stall_on = 1'b0;
  bit            fin_flag = 1'b0;
  bit            ar_wait = 1'b0;
  logic [AW-1:0] ar_prev = '0;
  string         ar_tag = "R3";

  function automatic logic [DW-1:0] mkdata(logic [31:0] a, int b);
    return {4{a, 32'(b) ^ 32'h5A5A0000}};
  endfunction

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor and slave model: drive at falling edge, observe shortly after
  initial begin
    usr_ready = 1'b1; ar_ready = 1'b0; r_valid = 1'b0; r_last = 1'b0; r_data = '0;
    forever begin
      @(negedge clk);
      usr_ready = stall_on ? ($urandom % 4 != 0) : 1'b1;
      ar_ready  = ($urandom % 3 != 0);
      if (!s_act && s_pend.size() > 0) begin
        s_act  = 1'b1;
        s_addr = s_pend.pop_front();
        s_beat = 0;
      end
      r_valid = s_act && ($urandom % 5 != 0);
      r_data  = mkdata(s_addr, s_beat);
      r_last  = s_act && (s_beat == BEATS - 1);
      #0.5;
      if (fin_flag) begin
        check(busy == 1'b0, "R10", "busy after final handshake", DW'(busy), '0);
        fin_flag = 1'b0;
      end
      if (ar_valid) begin
        if (ar_wait) check(ar_addr == ar_prev, "R5", "held ar_addr", ar_addr, ar_prev);
        check(!s_act, "R6", "ar_valid with burst open", DW'(s_act), '0);
        if (ar_ready) begin
          check(ar_len == 8'hFF && ar_size == 3'd5 && ar_burst == 2'b01 && ar_id == '0,
                "R2", "ar fields", {ar_id, ar_len, ar_size, ar_burst}, {4'h0, 8'hFF, 3'd5, 2'b01});
          if (exp_ar.size() == 0) begin
            check(1'b0, "R11", "unexpected AR", ar_addr, '0);
          end else begin
            logic [AW-1:0] ea;
            ea = exp_ar.pop_front();
            check(ar_addr == ea, ar_tag, "AR address", ar_addr, ea);
          end
          s_pend.push_back(ar_addr);
        end
      end
      ar_wait = ar_valid && !ar_ready;
      ar_prev = ar_addr;
      if (s_act && r_valid) begin
        if (exp_beat.size() == 0) begin
          check(r_ready && !usr_valid, "R9", "surplus beat drained", {r_ready, usr_valid}, 2'b10);
        end else begin
          check(r_ready == usr_ready, "R7", "r_ready follows user", DW'(r_ready), DW'(usr_ready));
          check(usr_valid, "R7", "usr_valid follows r_valid", DW'(usr_valid), 1);
        end
      end
      if (usr_valid && usr_ready) begin
        if (exp_beat.size() == 0) begin
          check(1'b0, "R7", "unexpected user beat", usr_data, '0);
        end else begin
          logic [DW:0] eb;
          eb = exp_beat.pop_front();
          check(usr_data == eb[DW-1:0], "R7", "user data", usr_data, eb[DW-1:0]);
          check(usr_last == eb[DW], "R8", "user last", DW'(usr_last), DW'(eb[DW]));
        end
      end
      if (s_act && r_valid && r_ready) begin
        s_beat++;
        if (s_beat == BEATS) begin
          s_act = 1'b0;
          if (exp_beat.size() == 0 && exp_ar.size() == 0) fin_flag = 1'b1;
        end
      end
    end
  end

  task automatic start_read(logic [AW-1:0] a, int len, logic [AW-1:0] lim);
    logic [AW-1:0] cur;
    logic [AW:0]   sum;
    int nb;
    cur = a;
    nb  = (len + BEATS - 1) / BEATS;
    for (int k = 0; k < nb; k++) begin
      exp_ar.push_back(cur);
      for (int b = 0; b < BEATS; b++) begin
        int idx;
        idx = k * BEATS + b;
        if (idx < len) exp_beat.push_back({idx == len - 1, mkdata(cur, b)});
      end
      sum = {1'b0, cur} + {1'b0, STR};
      cur = (sum > {1'b0, lim}) ? a : sum[AW-1:0];
    end
    @(negedge clk);
    end_addr = lim; req_addr = a; req_len = LW'(len); req_en = 1'b1;
    @(negedge clk);
    req_en = 1'b0;
    #0.5;
    check(busy == 1'b1 && ar_valid == 1'b1, "R10", "busy/ar_valid rise", {busy, ar_valid}, 2'b11);
    check(ar_addr == a, "R3", "first address", ar_addr, a);
  endtask

  task automatic wait_read();
    int guard;
    guard = 0;
    while ((busy || exp_beat.size() != 0) && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    #0.5;
    check(exp_beat.size() == 0 && exp_ar.size() == 0 && !busy, "R8", "request fully delivered",
          DW'(exp_beat.size()), '0);
  endtask

  initial begin
    rst_n = 1'b0; calib_done = 1'b0; req_en = 1'b0;
    req_addr = '0; req_len = '0; end_addr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    #0.5;
    check(!busy && !ar_valid && !usr_valid, "R1", "reset outputs", {busy, ar_valid, usr_valid}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    req_addr = 32'h40; req_len = 32'd8; req_en = 1'b1;
    @(negedge clk);
    req_en = 1'b0;
    @(negedge clk);
    #0.5;
    check(!busy && !ar_valid, "R1", "request ignored while calibration low", {busy, ar_valid}, '0);
    calib_done = 1'b1;
    repeat (3) @(negedge clk);

    ar_tag = "R3";
    start_read(32'h0000_0100, 5, 32'hFFFF_FFFF);
    wait_read();

    stall_on = 1'b1;
    start_read(32'h1000_0000, 2 * BEATS + 10, 32'hFFFF_FFFF);
    wait_read();

    ar_tag = "R4";
    start_read(32'h0000_1000, 700, 32'h0000_4FFF);
    wait_read();

    ar_tag = "R3";
    stall_on = 1'b0;
    start_read(32'h2000_0000, 2 * BEATS, 32'hFFFF_FFFF);
    wait_read();

    stall_on = 1'b1;
    start_read(32'h3000_0000, BEATS + 3, 32'hFFFF_FFFF);
    repeat (30) @(negedge clk);
    req_addr = 32'h7777_0000; req_len = 32'd4; req_en = 1'b1;
    @(negedge clk);
    req_en = 1'b0;
    #0.5;
    check(busy == 1'b1, "R11", "busy kept during ignored request", DW'(busy), 1);
    wait_read();

    @(negedge clk);
    req_addr = 32'h5000; req_len = '0; req_en = 1'b1;
    @(negedge clk);
    req_en = 1'b0;
    #0.5;
    check(!busy && !ar_valid, "R11", "zero-length request ignored", {busy, ar_valid}, '0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule